// File: doc/BRIEF.md
# Multi-Processor Interrupt Latch Mesh

This block collects every interrupt request that flows between three processors sharing one board: a main processor with three request inputs (non-maskable, fast and normal), a sub processor and a sound processor, each with one normal request input. Requests come from two sources. Video timing strobes raise the main processor's non-maskable line once per frame and its fast line every eighth scanline. Register writes let each side raise the other's request line. Every request stays latched and drives a level output until a dedicated clear action drops it.

A write of a sound command stores the byte in a command latch and raises the sound processor's request line. The sound processor's read of that byte acknowledges it. Two small control registers share the same write decoding. On the main side, the register holds a three-bit layer priority code and a ROM bank select. On the sub side, the register holds a single bank select bit. All outputs come straight from flip-flops, so every effect appears one clock after the strobe or write that causes it.

Top module: `cpu_irq_mesh`

## Requirements
- R1: While `rst` is high at a clock edge, every request output, the command byte, the priority code and both bank selects are zero after that edge.
- R2: A `vblank_pulse` sets `main_nmi`. The line stays high until a main write to offset 1 clears it.
- R3: A `line8_pulse` sets `main_firq`. The line stays high until a main write to offset 2 clears it.
- R4: A sub write to offset 0 sets `main_irq`. The line stays high until a main write to offset 3 clears it.
- R5: A main write to offset 4 sets `sub_irq`. The line stays high until a sub write to offset 1 clears it.
- R6: A main write to offset 0 loads `main_wdata` into `snd_cmd` and sets `snd_irq`. A `snd_rd` strobe clears `snd_irq` and leaves `snd_cmd` unchanged.
- R7: When a set and a clear reach the same request latch in the same cycle, the latch ends up set.
- R8: A main write to offset 5 loads `layer_pri` from data bits 2:0 and `main_bank` from data bit 3. Data bits 7:4 are ignored.
- R9: A sub write to offset 2 loads `sub_bank` from data bit 0. The other data bits are ignored.
- R10: Main writes to offsets 6 to 15 and sub writes to offset 3 change no output. Address and data presented while the write strobe is low also change no output.
- R11: Every output changes only at the first clock edge after its cause; nothing passes combinationally from an input to an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vblank_pulse | input | 1 | One-cycle strobe at the start of vertical blank |
| line8_pulse | input | 1 | One-cycle strobe every eighth scanline |
| main_wr | input | 1 | Main-side register write strobe |
| main_addr | input | 4 | Main-side register offset |
| main_wdata | input | 8 | Main-side write data |
| sub_wr | input | 1 | Sub-side register write strobe |
| sub_addr | input | 2 | Sub-side register offset |
| sub_wdata | input | 8 | Sub-side write data |
| snd_rd | input | 1 | Sound-side command read strobe (acknowledge) |
| main_nmi | output | 1 | Main non-maskable request level |
| main_firq | output | 1 | Main fast request level |
| main_irq | output | 1 | Main normal request level |
| sub_irq | output | 1 | Sub request level |
| snd_irq | output | 1 | Sound request level |
| snd_cmd | output | 8 | Latched sound command byte |
| layer_pri | output | 3 | Layer priority code |
| main_bank | output | 1 | Main ROM bank select |
| sub_bank | output | 1 | Sub ROM bank select |

## Verification
The assertions check the cycle-level rules on every cycle. These rules cover reset clearing, each set source taking effect one edge later even when a clear collides with it, each clear taking effect when no set competes, and request levels holding steady when no clear arrives. They also check that the control registers keep their value unless their own offset is written. Only the bench's scenarios can show full cross-processor handshakes over time, for example main raising sub, sub acknowledging, then sub raising main and main clearing it. The bench scenarios also cover the masking of the unused data bits, the full sweep of unused offsets and a reset in the middle of traffic.

// File: rtl/irq_mesh_pkg.sv
package irq_mesh_pkg;
  // Request latch indices.
  localparam int IDX_NMI  = 0;
  localparam int IDX_FIRQ = 1;
  localparam int IDX_MIRQ = 2;
  localparam int IDX_SUB  = 3;
  localparam int IDX_SND  = 4;
  localparam int NUM_REQ  = 5;

  // Main-side offsets. The clear/clear/clear/assert run must stay consecutive.
  localparam int MOFS_SND_CMD  = 0;
  localparam int MOFS_NMI_CLR  = 1;
  localparam int MOFS_FIRQ_CLR = 2;
  localparam int MOFS_MIRQ_CLR = 3;
  localparam int MOFS_SUB_SET  = 4;
  localparam int MOFS_CTRL     = 5;

  // Sub-side offsets.
  localparam int SOFS_MIRQ_SET = 0;
  localparam int SOFS_SUB_CLR  = 1;
  localparam int SOFS_CTRL     = 2;

  // Main control register field positions.
  localparam int PRI_LSB  = 0;
  localparam int BANK_BIT = 3;
endpackage

// File: rtl/irq_mesh_latch.sv
module irq_mesh_latch #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        q_o[g] <= 1'b0;
      else if (set_i[g])
        q_o[g] <= 1'b1;
      else if (clr_i[g])
        q_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_mesh_reg.sv
module irq_mesh_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst)
      q_o <= '0;
    else if (load_i)
      q_o <= d_i;
  end
endmodule

// File: rtl/irq_mesh_main_dec.sv
module irq_mesh_main_dec
  import irq_mesh_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  output logic          snd_load_o,
  output logic          nmi_clr_o,
  output logic          firq_clr_o,
  output logic          mirq_clr_o,
  output logic          sub_set_o,
  output logic          ctrl_load_o
);
  always_comb begin
    snd_load_o  = wr_i && (addr_i == AW'(MOFS_SND_CMD));
    nmi_clr_o   = wr_i && (addr_i == AW'(MOFS_NMI_CLR));
    firq_clr_o  = wr_i && (addr_i == AW'(MOFS_FIRQ_CLR));
    mirq_clr_o  = wr_i && (addr_i == AW'(MOFS_MIRQ_CLR));
    sub_set_o   = wr_i && (addr_i == AW'(MOFS_SUB_SET));
    ctrl_load_o = wr_i && (addr_i == AW'(MOFS_CTRL));
  end
endmodule

// File: rtl/irq_mesh_sub_dec.sv
module irq_mesh_sub_dec
  import irq_mesh_pkg::*;
#(
  parameter int AW = 2
) (
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  output logic          mirq_set_o,
  output logic          sub_clr_o,
  output logic          ctrl_load_o
);
  always_comb begin
    mirq_set_o  = wr_i && (addr_i == AW'(SOFS_MIRQ_SET));
    sub_clr_o   = wr_i && (addr_i == AW'(SOFS_SUB_CLR));
    ctrl_load_o = wr_i && (addr_i == AW'(SOFS_CTRL));
  end
endmodule

// File: rtl/cpu_irq_mesh.sv
module cpu_irq_mesh
  import irq_mesh_pkg::*;
#(
  parameter int MAIN_AW = 4,
  parameter int SUB_AW  = 2,
  parameter int DATA_W  = 8,
  parameter int PRI_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               vblank_pulse,
  input  logic               line8_pulse,
  input  logic               main_wr,
  input  logic [MAIN_AW-1:0] main_addr,
  input  logic [DATA_W-1:0]  main_wdata,
  input  logic               sub_wr,
  input  logic [SUB_AW-1:0]  sub_addr,
  input  logic [DATA_W-1:0]  sub_wdata,
  input  logic               snd_rd,
  output logic               main_nmi,
  output logic               main_firq,
  output logic               main_irq,
  output logic               sub_irq,
  output logic               snd_irq,
  output logic [DATA_W-1:0]  snd_cmd,
  output logic [PRI_W-1:0]   layer_pri,
  output logic               main_bank,
  output logic               sub_bank
);
  localparam int CTRL_W = PRI_W + 1;

  logic snd_load, nmi_clr, firq_clr, mirq_clr, sub_set, mctrl_load;
  logic mirq_set, sub_clr, sctrl_load;
  logic [NUM_REQ-1:0] req_set, req_clr, req_q;
  logic [CTRL_W-1:0]  mctrl_d, mctrl_q;
  logic               unused_data;

  irq_mesh_main_dec #(.AW(MAIN_AW)) u_main_dec (
    .wr_i(main_wr), .addr_i(main_addr),
    .snd_load_o(snd_load), .nmi_clr_o(nmi_clr), .firq_clr_o(firq_clr),
    .mirq_clr_o(mirq_clr), .sub_set_o(sub_set), .ctrl_load_o(mctrl_load)
  );

  irq_mesh_sub_dec #(.AW(SUB_AW)) u_sub_dec (
    .wr_i(sub_wr), .addr_i(sub_addr),
    .mirq_set_o(mirq_set), .sub_clr_o(sub_clr), .ctrl_load_o(sctrl_load)
  );

  always_comb begin
    req_set           = '0;
    req_clr           = '0;
    req_set[IDX_NMI]  = vblank_pulse;
    req_clr[IDX_NMI]  = nmi_clr;
    req_set[IDX_FIRQ] = line8_pulse;
    req_clr[IDX_FIRQ] = firq_clr;
    req_set[IDX_MIRQ] = mirq_set;
    req_clr[IDX_MIRQ] = mirq_clr;
    req_set[IDX_SUB]  = sub_set;
    req_clr[IDX_SUB]  = sub_clr;
    req_set[IDX_SND]  = snd_load;
    req_clr[IDX_SND]  = snd_rd;
  end

  irq_mesh_latch #(.N(NUM_REQ)) u_req (
    .clk(clk), .rst(rst), .set_i(req_set), .clr_i(req_clr), .q_o(req_q)
  );

  irq_mesh_reg #(.W(DATA_W)) u_snd_cmd (
    .clk(clk), .rst(rst), .load_i(snd_load), .d_i(main_wdata), .q_o(snd_cmd)
  );

  assign mctrl_d = {main_wdata[BANK_BIT], main_wdata[PRI_LSB +: PRI_W]};

  irq_mesh_reg #(.W(CTRL_W)) u_main_ctrl (
    .clk(clk), .rst(rst), .load_i(mctrl_load), .d_i(mctrl_d), .q_o(mctrl_q)
  );

  irq_mesh_reg #(.W(1)) u_sub_ctrl (
    .clk(clk), .rst(rst), .load_i(sctrl_load), .d_i(sub_wdata[0]), .q_o(sub_bank)
  );

  assign unused_data = ^{main_wdata[DATA_W-1:CTRL_W], sub_wdata[DATA_W-1:1]};

  assign main_nmi  = req_q[IDX_NMI];
  assign main_firq = req_q[IDX_FIRQ];
  assign main_irq  = req_q[IDX_MIRQ];
  assign sub_irq   = req_q[IDX_SUB];
  assign snd_irq   = req_q[IDX_SND];
  assign layer_pri = mctrl_q[PRI_W-1:0];
  assign main_bank = mctrl_q[PRI_W];
endmodule

// File: rtl/irq_mesh_chk.sv
module irq_mesh_chk
  import irq_mesh_pkg::*;
#(
  parameter int MAIN_AW = 4,
  parameter int SUB_AW  = 2,
  parameter int DATA_W  = 8,
  parameter int PRI_W   = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               vblank_pulse,
  input logic               line8_pulse,
  input logic               main_wr,
  input logic [MAIN_AW-1:0] main_addr,
  input logic [DATA_W-1:0]  main_wdata,
  input logic               sub_wr,
  input logic [SUB_AW-1:0]  sub_addr,
  input logic [DATA_W-1:0]  sub_wdata,
  input logic               snd_rd,
  input logic               main_nmi,
  input logic               main_firq,
  input logic               main_irq,
  input logic               sub_irq,
  input logic               snd_irq,
  input logic [DATA_W-1:0]  snd_cmd,
  input logic [PRI_W-1:0]   layer_pri,
  input logic               main_bank,
  input logic               sub_bank
);
  logic mw_snd, mw_nmi, mw_firq, mw_mirq, mw_sub, mw_ctrl;
  logic sw_mirq, sw_sub, sw_ctrl;
  assign mw_snd  = main_wr && main_addr == MAIN_AW'(MOFS_SND_CMD);
  assign mw_nmi  = main_wr && main_addr == MAIN_AW'(MOFS_NMI_CLR);
  assign mw_firq = main_wr && main_addr == MAIN_AW'(MOFS_FIRQ_CLR);
  assign mw_mirq = main_wr && main_addr == MAIN_AW'(MOFS_MIRQ_CLR);
  assign mw_sub  = main_wr && main_addr == MAIN_AW'(MOFS_SUB_SET);
  assign mw_ctrl = main_wr && main_addr == MAIN_AW'(MOFS_CTRL);
  assign sw_mirq = sub_wr && sub_addr == SUB_AW'(SOFS_MIRQ_SET);
  assign sw_sub  = sub_wr && sub_addr == SUB_AW'(SOFS_SUB_CLR);
  assign sw_ctrl = sub_wr && sub_addr == SUB_AW'(SOFS_CTRL);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !main_nmi && !main_firq && !main_irq && !sub_irq && !snd_irq && snd_cmd == '0 && layer_pri == '0 && !main_bank && !sub_bank); // R1
  AST_NMI_SET: assert property (@(posedge clk) disable iff (rst) vblank_pulse |=> main_nmi); // R7
  AST_NMI_CLEAR: assert property (@(posedge clk) disable iff (rst) (mw_nmi && !vblank_pulse) |=> !main_nmi); // R2
  AST_NMI_HOLD: assert property (@(posedge clk) disable iff (rst) (main_nmi && !mw_nmi) |=> main_nmi); // R2
  AST_FIRQ_SET: assert property (@(posedge clk) disable iff (rst) line8_pulse |=> main_firq); // R3
  AST_FIRQ_CLEAR: assert property (@(posedge clk) disable iff (rst) (mw_firq && !line8_pulse) |=> !main_firq); // R3
  AST_MIRQ_SET: assert property (@(posedge clk) disable iff (rst) sw_mirq |=> main_irq); // R4
  AST_MIRQ_CLEAR: assert property (@(posedge clk) disable iff (rst) (mw_mirq && !sw_mirq) |=> !main_irq); // R4
  AST_SUB_SET: assert property (@(posedge clk) disable iff (rst) mw_sub |=> sub_irq); // R5
  AST_SUB_CLEAR: assert property (@(posedge clk) disable iff (rst) (sw_sub && !mw_sub) |=> !sub_irq); // R5
  AST_SND_LOAD: assert property (@(posedge clk) disable iff (rst) mw_snd |=> snd_irq && snd_cmd == $past(main_wdata)); // R6
  AST_SND_ACK: assert property (@(posedge clk) disable iff (rst) (snd_rd && !mw_snd) |=> !snd_irq && $stable(snd_cmd)); // R6
  AST_MCTRL_LOAD: assert property (@(posedge clk) disable iff (rst) mw_ctrl |=> layer_pri == $past(main_wdata[PRI_W-1:0]) && main_bank == $past(main_wdata[3])); // R8
  AST_SCTRL_LOAD: assert property (@(posedge clk) disable iff (rst) sw_ctrl |=> sub_bank == $past(sub_wdata[0])); // R9
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst) (!mw_ctrl && !sw_ctrl) |=> $stable(layer_pri) && $stable(main_bank) && $stable(sub_bank)); // R10
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst) (!main_wr && !sub_wr && !snd_rd && !vblank_pulse && !line8_pulse) |=> $stable(main_nmi) && $stable(main_firq) && $stable(main_irq) && $stable(sub_irq) && $stable(snd_irq) && $stable(snd_cmd)); // R11
endmodule

bind cpu_irq_mesh irq_mesh_chk #(
  .MAIN_AW(MAIN_AW), .SUB_AW(SUB_AW), .DATA_W(DATA_W), .PRI_W(PRI_W)
) u_chk (
  .clk(clk), .rst(rst), .vblank_pulse(vblank_pulse), .line8_pulse(line8_pulse),
  .main_wr(main_wr), .main_addr(main_addr), .main_wdata(main_wdata),
  .sub_wr(sub_wr), .sub_addr(sub_addr), .sub_wdata(sub_wdata), .snd_rd(snd_rd),
  .main_nmi(main_nmi), .main_firq(main_firq), .main_irq(main_irq),
  .sub_irq(sub_irq), .snd_irq(snd_irq), .snd_cmd(snd_cmd),
  .layer_pri(layer_pri), .main_bank(main_bank), .sub_bank(sub_bank)
);

// File: tb/cpu_irq_mesh_bench.sv
module cpu_irq_mesh_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       vblank_pulse, line8_pulse, main_wr, sub_wr, snd_rd;
  logic [3:0] main_addr;
  logic [1:0] sub_addr;
  logic [7:0] main_wdata, sub_wdata;
  logic       main_nmi, main_firq, main_irq, sub_irq, snd_irq, main_bank, sub_bank;
  logic [7:0] snd_cmd;
  logic [2:0] layer_pri;

  // bench model
  logic       m_nmi, m_firq, m_mirq, m_sub, m_snd, m_bank, m_sbank;
  logic [7:0] m_cmd;
  logic [2:0] m_pri;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  cpu_irq_mesh u_cpu_irq_mesh (
    .clk(clk), .rst(rst), .vblank_pulse(vblank_pulse), .line8_pulse(line8_pulse),
    .main_wr(main_wr), .main_addr(main_addr), .main_wdata(main_wdata),
    .sub_wr(sub_wr), .sub_addr(sub_addr), .sub_wdata(sub_wdata), .snd_rd(snd_rd),
    .main_nmi(main_nmi), .main_firq(main_firq), .main_irq(main_irq),
    .sub_irq(sub_irq), .snd_irq(snd_irq), .snd_cmd(snd_cmd),
    .layer_pri(layer_pri), .main_bank(main_bank), .sub_bank(sub_bank)
  );

  always #10 clk = ~clk;

  function automatic logic nx(logic q, logic s, logic c);
    return s | (q & ~c);
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    vblank_pulse = 0; line8_pulse = 0; main_wr = 0; sub_wr = 0; snd_rd = 0;
    main_addr = 0; sub_addr = 0; main_wdata = 0; sub_wdata = 0;
  endtask

  task automatic model_step();
    if (rst) begin
      m_nmi = 0; m_firq = 0; m_mirq = 0; m_sub = 0; m_snd = 0;
      m_cmd = 0; m_pri = 0; m_bank = 0; m_sbank = 0;
    end else begin
      m_nmi  = nx(m_nmi,  vblank_pulse, main_wr && main_addr == 1);
      m_firq = nx(m_firq, line8_pulse,  main_wr && main_addr == 2);
      m_mirq = nx(m_mirq, sub_wr && sub_addr == 0, main_wr && main_addr == 3);
      m_sub  = nx(m_sub,  main_wr && main_addr == 4, sub_wr && sub_addr == 1);
      m_snd  = nx(m_snd,  main_wr && main_addr == 0, snd_rd);
      if (main_wr && main_addr == 0) m_cmd = main_wdata;
      if (main_wr && main_addr == 5) begin
        m_pri  = main_wdata[2:0];
        m_bank = main_wdata[3];
      end
      if (sub_wr && sub_addr == 2) m_sbank = sub_wdata[0];
    end
  endtask

  task automatic check_all();
    chk("R2 main_nmi",  {7'd0, main_nmi},  {7'd0, m_nmi});
    chk("R3 main_firq", {7'd0, main_firq}, {7'd0, m_firq});
    chk("R4 main_irq",  {7'd0, main_irq},  {7'd0, m_mirq});
    chk("R5 sub_irq",   {7'd0, sub_irq},   {7'd0, m_sub});
    chk("R6 snd_irq",   {7'd0, snd_irq},   {7'd0, m_snd});
    chk("R6 snd_cmd",   snd_cmd,           m_cmd);
    chk("R8 layer_pri", {5'd0, layer_pri}, {5'd0, m_pri});
    chk("R8 main_bank", {7'd0, main_bank}, {7'd0, m_bank});
    chk("R9 sub_bank",  {7'd0, sub_bank},  {7'd0, m_sbank});
  endtask

  // apply current inputs across one edge, update model, compare (R11 latency)
  task automatic tick();
    @(posedge clk);
    #2;
    model_step();
    check_all();
    idle_inputs();
  endtask

  task automatic mwrite(int a, logic [7:0] d);
    main_wr = 1; main_addr = 4'(a); main_wdata = d; tick();
  endtask

  task automatic swrite(int a, logic [7:0] d);
    sub_wr = 1; sub_addr = 2'(a); sub_wdata = d; tick();
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    idle_inputs();
    rst = 1;
    m_nmi = 0; m_firq = 0; m_mirq = 0; m_sub = 0; m_snd = 0;
    m_cmd = 0; m_pri = 0; m_bank = 0; m_sbank = 0;
    // R1 reset state, with junk on the inputs
    vblank_pulse = 1; main_wr = 1; main_addr = 0; main_wdata = 8'hAA;
    tick(); tick();
    chk("R1 reset all zero", {main_nmi, main_firq, main_irq, sub_irq, snd_irq, main_bank, sub_bank, 1'b0}, 8'h00);
    chk("R1 reset cmd zero", snd_cmd, 8'h00);
    rst = 0;

    // R11: no combinational path, output low before the edge
    vblank_pulse = 1; #1;
    chk("R11 nmi not before edge", {7'd0, main_nmi}, 8'h00);
    tick();
    chk("R2 nmi set", {7'd0, main_nmi}, 8'h01);
    repeat (3) tick();
    chk("R2 nmi held", {7'd0, main_nmi}, 8'h01);
    mwrite(1, 8'h00);
    chk("R2 nmi cleared", {7'd0, main_nmi}, 8'h00);

    // R3 fast request
    line8_pulse = 1; tick();
    mwrite(2, 8'h00);
    chk("R3 firq cleared", {7'd0, main_firq}, 8'h00);

    // R7 collisions: set wins
    vblank_pulse = 1; main_wr = 1; main_addr = 1; tick();
    chk("R7 nmi set beats clear", {7'd0, main_nmi}, 8'h01);
    main_wr = 1; main_addr = 4; sub_wr = 1; sub_addr = 1; tick();
    chk("R7 sub set beats clear", {7'd0, sub_irq}, 8'h01);
    sub_wr = 1; sub_addr = 0; main_wr = 1; main_addr = 3; tick();
    chk("R7 main irq set beats clear", {7'd0, main_irq}, 8'h01);
    main_wr = 1; main_addr = 0; main_wdata = 8'h3C; snd_rd = 1; tick();
    chk("R7 snd set beats ack", {7'd0, snd_irq}, 8'h01);

    // R4/R5 handshake
    swrite(1, 8'h00);
    chk("R5 sub cleared by sub", {7'd0, sub_irq}, 8'h00);
    mwrite(3, 8'h00);
    chk("R4 main irq cleared", {7'd0, main_irq}, 8'h00);

    // R6 acknowledge keeps byte
    mwrite(0, 8'hC7);
    snd_rd = 1; tick();
    chk("R6 ack clears irq", {7'd0, snd_irq}, 8'h00);
    chk("R6 ack keeps byte", snd_cmd, 8'hC7);

    // R8 control fields
    mwrite(5, 8'hF5);
    chk("R8 pri from bits 2:0", {5'd0, layer_pri}, 8'h05);
    chk("R8 bank bit 3 clear", {7'd0, main_bank}, 8'h00);
    mwrite(5, 8'h0A);
    chk("R8 bank bit 3 set", {7'd0, main_bank}, 8'h01);
    // R9
    swrite(2, 8'hFE);
    chk("R9 sub bank bit 0", {7'd0, sub_bank}, 8'h00);
    swrite(2, 8'h01);
    chk("R9 sub bank set", {7'd0, sub_bank}, 8'h01);

    // R10 unused offsets and strobe low
    for (int a = 6; a < 16; a++) mwrite(a, 8'hFF);
    swrite(3, 8'hFF);
    main_addr = 5; main_wdata = 8'h00; sub_addr = 2; sub_wdata = 8'h00; tick();
    chk("R10 ignored writes pri", {5'd0, layer_pri}, 8'h02);
    chk("R10 ignored writes banks", {6'd0, main_bank, sub_bank}, 8'h03);
    chk("R10 ignored writes irqs", {3'd0, main_nmi, main_firq, main_irq, sub_irq, snd_irq}, 8'h10);

    // random traffic, with an occasional reset
    for (int i = 0; i < 4000; i++) begin
      rst          = ($urandom_range(0, 199) == 0);
      vblank_pulse = ($urandom_range(0, 7) == 0);
      line8_pulse  = ($urandom_range(0, 3) == 0);
      main_wr      = $urandom_range(0, 1);
      main_addr    = 4'($urandom_range(0, 7));
      main_wdata   = 8'($urandom);
      sub_wr       = $urandom_range(0, 1);
      sub_addr     = 2'($urandom_range(0, 3));
      sub_wdata    = 8'($urandom);
      snd_rd       = ($urandom_range(0, 3) == 0);
      tick();
    end
    rst = 0;

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule